// File: doc/BRIEF.md
# CPI-Proportional Shared-Cache Way Allocator

This block decides how many ways of a shared cache each of four hardware threads may hold. It watches per-thread event strobes for elapsed cycles, retired instructions, cache hits and cache misses. Once the threads together have retired a configurable number of instructions, it closes the interval. It computes a fixed-point cycles-per-instruction figure for each thread and splits the ways in proportion to those figures. Threads that stall more get a larger share of the cache.

Each thread keeps one guaranteed way. The remaining ways are divided by a single sequential restoring divider that is reused for every quotient. Floored shares leave a small remainder, and those leftover ways are handed out one at a time, highest CPI first. The new targets appear together with a one-cycle done pulse. A quota-enforcing replacement policy reads them from there. The hit and miss totals of the interval just closed are published in the same cycle.

Top module: `cpiWayAlloc`

## Requirements
- R1: Out of reset every thread's target equals TOTAL_WAYS/NUM_THR (4 with the defaults), `updateDone` is low and every published hit and miss count is zero.
- R2: Per thread, cycle, instruction, hit and miss strobes are counted over the interval. The interval's hit and miss totals are published on `hitCount`/`missCount` (thread t in bits [t*32 +: 32]) together with the new targets.
- R3: An interval closes in the cycle where the instructions retired by all threads since the previous close, counting that cycle's strobes, reach `intervalLen`. That cycle's events belong to the closing interval, the next cycle's events belong to the new one, and all counters restart from zero.
- R4: A thread's CPI is floor(cycles*256/instructions), clamped to the range 1..65535. A thread that retired no instructions gets 65535.
- R5: Before remainder handling, a thread's target is 1 + floor(CPI_t * (TOTAL_WAYS-NUM_THR) / sum of all CPIs).
- R6: Leftover ways, (TOTAL_WAYS-NUM_THR) minus the sum of the floored shares, go one each to the threads with the highest CPI. Equal CPIs rank the lower thread index first. The published targets always sum to TOTAL_WAYS.
- R7: Every published target is at least 1.
- R8: Targets and counts change only in the cycle where `updateDone` is high, and `updateDone` is a single-cycle pulse.
- R9: A thread whose CPI is strictly higher than another's never receives fewer ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intervalLen | input | 32 | Total retired instructions per interval |
| cycleEvt | input | 4 | Per-thread cycle strobe |
| instrEvt | input | 4 | Per-thread retired-instruction strobe |
| hitEvt | input | 4 | Per-thread cache hit strobe |
| missEvt | input | 4 | Per-thread cache miss strobe |
| wayTarget | output | 20 | Per-thread way target, thread t in bits [t*5 +: 5] |
| hitCount | output | 128 | Hits in the last closed interval, per thread |
| missCount | output | 128 | Misses in the last closed interval, per thread |
| updateDone | output | 1 | One-cycle pulse when new values are published |

## Verification
The bound checker watches four properties on every cycle: the targets sum to the total way count, no target falls below one, the outputs hold still between done pulses, and the done pulse lasts one cycle. The bench scenarios are needed for the arithmetic. They cover CPI saturation and the zero-instruction case, the clamp of a zero-cycle thread to the minimum CPI, tie ranking during remainder handout, and which interval owns an event that lands exactly on a boundary cycle or just after it.

// File: rtl/cpiWayAllocPkg.sv
package cpiWayAllocPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // snapshot counters and restart them
    logic divStart;    // launch one division
    logic phaseShare;  // 0: CPI division, 1: share division
    logic storeCpi;    // write quotient as CPI of selected thread
    logic loadSum;     // register sum of CPIs
    logic storeShare;  // write quotient as share of selected thread
    logic publish;     // update outputs and pulse done
  } wayStrobe_t;
endpackage

// File: rtl/cpiWayDivider.sv
module cpiWayDivider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [CW-1:0] left;
  logic          run;
  logic [W:0]    remShift;
  logic [W:0]    remSub;

  always_comb begin
    remShift = {rem[W-1:0], quo[W-1]};
    remSub   = remShift - {1'b0, divisor};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      quo  <= dividend;
      left <= CW'(W);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      if (!remSub[W]) begin
        rem <= remSub;
        quo <= {quo[W-2:0], 1'b1};
      end else begin
        rem <= remShift;
        quo <= {quo[W-2:0], 1'b0};
      end
      left <= left - CW'(1);
      if (left == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = quo;
endmodule

// File: rtl/cpiWayAllocCtrl.sv
module cpiWayAllocCtrl
  import cpiWayAllocPkg::*;
#(
  parameter int NUM_THR = 4,
  localparam int IDX_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intervalEnd,
  input  logic             divDone,
  output wayStrobe_t       stb,
  output logic [IDX_W-1:0] thrSel
);
  typedef enum logic [2:0] {
    S_IDLE, S_CPI_GO, S_CPI_WAIT, S_SUM, S_SHR_GO, S_SHR_WAIT, S_PUB
  } state_t;

  state_t state, stateNext;
  logic [IDX_W-1:0] idxNext;
  logic lastThr;

  assign lastThr = (thrSel == IDX_W'(NUM_THR - 1));

  always_comb begin
    stb       = '0;
    stateNext = state;
    idxNext   = thrSel;
    unique case (state)
      S_IDLE: if (intervalEnd) begin
        stb.capture = 1'b1;
        idxNext     = '0;
        stateNext   = S_CPI_GO;
      end
      S_CPI_GO: begin
        stb.divStart = 1'b1;
        stateNext    = S_CPI_WAIT;
      end
      S_CPI_WAIT: if (divDone) begin
        stb.storeCpi = 1'b1;
        if (lastThr) stateNext = S_SUM;
        else begin
          idxNext   = thrSel + IDX_W'(1);
          stateNext = S_CPI_GO;
        end
      end
      S_SUM: begin
        stb.loadSum = 1'b1;
        idxNext     = '0;
        stateNext   = S_SHR_GO;
      end
      S_SHR_GO: begin
        stb.phaseShare = 1'b1;
        stb.divStart   = 1'b1;
        stateNext      = S_SHR_WAIT;
      end
      S_SHR_WAIT: begin
        stb.phaseShare = 1'b1;
        if (divDone) begin
          stb.storeShare = 1'b1;
          if (lastThr) stateNext = S_PUB;
          else begin
            idxNext   = thrSel + IDX_W'(1);
            stateNext = S_SHR_GO;
          end
        end
      end
      S_PUB: begin
        stb.publish = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      thrSel <= '0;
    end else begin
      state  <= stateNext;
      thrSel <= idxNext;
    end
  end
endmodule

// File: rtl/cpiWayAllocDatapath.sv
module cpiWayAllocDatapath
  import cpiWayAllocPkg::*;
#(
  parameter int NUM_THR    = 4,
  parameter int TOTAL_WAYS = 16,
  parameter int CNT_W      = 32,
  parameter int FRAC_W     = 8,
  parameter int CPI_W      = 16,
  localparam int IDX_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int TW    = $clog2(TOTAL_WAYS + 1),
  localparam int DW    = CNT_W + FRAC_W,
  localparam int SUM_W = CPI_W + $clog2(NUM_THR + 1),
  localparam int SPARE = TOTAL_WAYS - NUM_THR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         intervalLen,
  input  logic [NUM_THR-1:0]       cycleEvt,
  input  logic [NUM_THR-1:0]       instrEvt,
  input  logic [NUM_THR-1:0]       hitEvt,
  input  logic [NUM_THR-1:0]       missEvt,
  input  wayStrobe_t               stb,
  input  logic [IDX_W-1:0]         thrSel,
  output logic                     intervalEnd,
  output logic                     divDone,
  output logic [NUM_THR*TW-1:0]    wayTarget,
  output logic [NUM_THR*CNT_W-1:0] hitCount,
  output logic [NUM_THR*CNT_W-1:0] missCount,
  output logic                     updateDone
);
  localparam logic [CPI_W-1:0] CPI_MAX = '1;

  logic [CNT_W-1:0] cycCnt [NUM_THR];
  logic [CNT_W-1:0] insCnt [NUM_THR];
  logic [CNT_W-1:0] hitCnt [NUM_THR];
  logic [CNT_W-1:0] missCnt[NUM_THR];
  logic [CNT_W-1:0] cycSnap [NUM_THR];
  logic [CNT_W-1:0] insSnap [NUM_THR];
  logic [CNT_W-1:0] hitSnap [NUM_THR];
  logic [CNT_W-1:0] missSnap[NUM_THR];
  logic [CPI_W-1:0] cpiReg  [NUM_THR];
  logic [TW-1:0]    shareReg[NUM_THR];
  logic [TW-1:0]    newTarget[NUM_THR];
  logic [TW-1:0]    rankOf  [NUM_THR];
  logic [SUM_W-1:0] cpiSum, cpiSumNext;
  logic [TW-1:0]    shareSum, spareLeft;
  logic [CNT_W-1:0] instrTotal, instrInc;
  logic [DW-1:0]    dividend, divisor, quo;

  // interval detection on total retired instructions
  always_comb begin
    instrInc = '0;
    for (int i = 0; i < NUM_THR; i++) instrInc = instrInc + CNT_W'(instrEvt[i]);
  end
  assign intervalEnd = (instrTotal + instrInc) >= intervalLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instrTotal <= '0;
      for (int t = 0; t < NUM_THR; t++) begin
        cycCnt[t] <= '0; insCnt[t] <= '0; hitCnt[t] <= '0; missCnt[t] <= '0;
        cycSnap[t] <= '0; insSnap[t] <= '0; hitSnap[t] <= '0; missSnap[t] <= '0;
      end
    end else if (stb.capture) begin
      instrTotal <= '0;
      for (int t = 0; t < NUM_THR; t++) begin
        cycSnap[t]  <= cycCnt[t]  + CNT_W'(cycleEvt[t]);
        insSnap[t]  <= insCnt[t]  + CNT_W'(instrEvt[t]);
        hitSnap[t]  <= hitCnt[t]  + CNT_W'(hitEvt[t]);
        missSnap[t] <= missCnt[t] + CNT_W'(missEvt[t]);
        cycCnt[t] <= '0; insCnt[t] <= '0; hitCnt[t] <= '0; missCnt[t] <= '0;
      end
    end else begin
      instrTotal <= instrTotal + instrInc;
      for (int t = 0; t < NUM_THR; t++) begin
        cycCnt[t]  <= cycCnt[t]  + CNT_W'(cycleEvt[t]);
        insCnt[t]  <= insCnt[t]  + CNT_W'(instrEvt[t]);
        hitCnt[t]  <= hitCnt[t]  + CNT_W'(hitEvt[t]);
        missCnt[t] <= missCnt[t] + CNT_W'(missEvt[t]);
      end
    end
  end

  // shared divider operands
  assign dividend = stb.phaseShare ? (DW'(cpiReg[thrSel]) * DW'(SPARE))
                                   : {cycSnap[thrSel], {FRAC_W{1'b0}}};
  assign divisor  = stb.phaseShare ? DW'(cpiSum) : DW'(insSnap[thrSel]);

  cpiWayDivider #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(stb.divStart),
    .dividend(dividend), .divisor(divisor),
    .done(divDone), .quotient(quo)
  );

  // sum of CPIs, floored-share remainder and CPI ranking
  always_comb begin
    cpiSumNext = '0;
    shareSum   = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      cpiSumNext = cpiSumNext + SUM_W'(cpiReg[i]);
      shareSum   = shareSum + shareReg[i];
    end
    spareLeft = TW'(SPARE) - shareSum;
    for (int i = 0; i < NUM_THR; i++) begin
      rankOf[i] = '0;
      for (int j = 0; j < NUM_THR; j++)
        if (j != i && (cpiReg[j] > cpiReg[i] || (cpiReg[j] == cpiReg[i] && j < i)))
          rankOf[i] = rankOf[i] + TW'(1);
      newTarget[i] = shareReg[i] + TW'(1) + ((rankOf[i] < spareLeft) ? TW'(1) : TW'(0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpiSum     <= '0;
      updateDone <= 1'b0;
      for (int t = 0; t < NUM_THR; t++) begin
        cpiReg[t]   <= '0;
        shareReg[t] <= '0;
        wayTarget[t*TW +: TW]      <= TW'(TOTAL_WAYS / NUM_THR);
        hitCount[t*CNT_W +: CNT_W]  <= '0;
        missCount[t*CNT_W +: CNT_W] <= '0;
      end
    end else begin
      updateDone <= stb.publish;
      if (stb.storeCpi) begin
        if (insSnap[thrSel] == '0 || quo > DW'(CPI_MAX)) cpiReg[thrSel] <= CPI_MAX;
        else if (quo == '0)                                cpiReg[thrSel] <= CPI_W'(1);
        else                                               cpiReg[thrSel] <= quo[CPI_W-1:0];
      end
      if (stb.loadSum)    cpiSum <= cpiSumNext;
      if (stb.storeShare) shareReg[thrSel] <= quo[TW-1:0];
      if (stb.publish) begin
        for (int t = 0; t < NUM_THR; t++) begin
          wayTarget[t*TW +: TW]      <= newTarget[t];
          hitCount[t*CNT_W +: CNT_W]  <= hitSnap[t];
          missCount[t*CNT_W +: CNT_W] <= missSnap[t];
        end
      end
    end
  end
endmodule

// File: rtl/cpiWayAlloc.sv
module cpiWayAlloc
  import cpiWayAllocPkg::*;
#(
  parameter int NUM_THR    = 4,
  parameter int TOTAL_WAYS = 16,
  parameter int CNT_W      = 32,
  parameter int FRAC_W     = 8,
  parameter int CPI_W      = 16,
  localparam int IDX_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int TW    = $clog2(TOTAL_WAYS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         intervalLen,
  input  logic [NUM_THR-1:0]       cycleEvt,
  input  logic [NUM_THR-1:0]       instrEvt,
  input  logic [NUM_THR-1:0]       hitEvt,
  input  logic [NUM_THR-1:0]       missEvt,
  output logic [NUM_THR*TW-1:0]    wayTarget,
  output logic [NUM_THR*CNT_W-1:0] hitCount,
  output logic [NUM_THR*CNT_W-1:0] missCount,
  output logic                     updateDone
);
  wayStrobe_t       stb;
  logic [IDX_W-1:0] thrSel;
  logic             intervalEnd;
  logic             divDone;

  cpiWayAllocCtrl #(.NUM_THR(NUM_THR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .intervalEnd(intervalEnd), .divDone(divDone),
    .stb(stb), .thrSel(thrSel)
  );

  cpiWayAllocDatapath #(
    .NUM_THR(NUM_THR), .TOTAL_WAYS(TOTAL_WAYS), .CNT_W(CNT_W),
    .FRAC_W(FRAC_W), .CPI_W(CPI_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .intervalLen(intervalLen),
    .cycleEvt(cycleEvt), .instrEvt(instrEvt), .hitEvt(hitEvt), .missEvt(missEvt),
    .stb(stb), .thrSel(thrSel), .intervalEnd(intervalEnd), .divDone(divDone),
    .wayTarget(wayTarget), .hitCount(hitCount), .missCount(missCount),
    .updateDone(updateDone)
  );
endmodule

// File: rtl/cpiWayAllocChecker.sv
module cpiWayAllocChecker #(
  parameter int NUM_THR    = 4,
  parameter int TOTAL_WAYS = 16,
  parameter int CNT_W      = 32,
  localparam int TW = $clog2(TOTAL_WAYS + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_THR*TW-1:0]    wayTarget,
  input logic [NUM_THR*CNT_W-1:0] hitCount,
  input logic [NUM_THR*CNT_W-1:0] missCount,
  input logic                     updateDone
);
  int  targetSum;
  logic anyZero;

  always_comb begin
    targetSum = 0;
    anyZero   = 1'b0;
    for (int i = 0; i < NUM_THR; i++) begin
      targetSum = targetSum + int'(wayTarget[i*TW +: TW]);
      if (wayTarget[i*TW +: TW] == '0) anyZero = 1'b1;
    end
  end

  // R6: targets always add up to the whole cache
  a_r6_sum_total: assert property (@(posedge clk) disable iff (!rst_n)
    targetSum == TOTAL_WAYS);

  // R7: no thread is starved of ways
  a_r7_min_one: assert property (@(posedge clk) disable iff (!rst_n)
    !anyZero);

  // R8: outputs only move together with the done pulse
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !updateDone |-> ($stable(wayTarget) && $stable(hitCount) && $stable(missCount)));

  // R8: done is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    updateDone |=> !updateDone);
endmodule

bind cpiWayAlloc cpiWayAllocChecker #(
  .NUM_THR(NUM_THR), .TOTAL_WAYS(TOTAL_WAYS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wayTarget(wayTarget), .hitCount(hitCount),
  .missCount(missCount), .updateDone(updateDone)
);

// File: tb/cpiWayAlloc_tb.sv
module cpiWayAlloc_tb;
  localparam int N = 4;
  localparam int WAYS = 16;
  localparam int TW = 5;
  localparam int CW = 32;

  typedef int quad_t [4];
  typedef struct {
    int tgt[4];
    int hit[4];
    int miss[4];
    longint cpi[4];
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] intervalLen = 32'd1000;
  logic [N-1:0] cycleEvt = '0, instrEvt = '0, hitEvt = '0, missEvt = '0;
  logic [N*TW-1:0] wayTarget;
  logic [N*CW-1:0] hitCount, missCount;
  logic updateDone;

  int checks = 0, fails = 0, doneCount = 0, carryHit0 = 0, cycleNo = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  cpiWayAlloc u_dut (
    .clk(clk), .rst_n(rst_n), .intervalLen(intervalLen),
    .cycleEvt(cycleEvt), .instrEvt(instrEvt), .hitEvt(hitEvt), .missEvt(missEvt),
    .wayTarget(wayTarget), .hitCount(hitCount), .missCount(missCount),
    .updateDone(updateDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycleNo++;
    if (cycleNo > 150000) begin
      check(1'b0, "WDOG", "watchdog expired", cycleNo, 150000);
      finishTest();
    end
  end

  // monitor: pop expected items when the design publishes
  always @(negedge clk) begin
    if (rst_n && updateDone) begin
      doneCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "unexpected update", doneCount, 0);
      end else begin
        expItem_t e;
        int s;
        e = expQ.pop_front();
        s = 0;
        for (int i = 0; i < N; i++) begin
          int act;
          act = int'(wayTarget[i*TW +: TW]);
          s += act;
          check(act == e.tgt[i], "R5/R6", $sformatf("target thread %0d", i), act, e.tgt[i]);
          check(act >= 1, "R7", $sformatf("min target thread %0d", i), act, 1);
          check(int'(hitCount[i*CW +: CW]) == e.hit[i], "R2/R3",
                $sformatf("hits thread %0d", i), hitCount[i*CW +: CW], e.hit[i]);
          check(int'(missCount[i*CW +: CW]) == e.miss[i], "R2/R3",
                $sformatf("misses thread %0d", i), missCount[i*CW +: CW], e.miss[i]);
        end
        check(s == WAYS, "R6", "target sum", s, WAYS);
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (e.cpi[i] > e.cpi[j])
              check(wayTarget[i*TW +: TW] >= wayTarget[j*TW +: TW], "R9",
                    $sformatf("order %0d over %0d", i, j),
                    wayTarget[i*TW +: TW], wayTarget[j*TW +: TW]);
      end
    end
  end

  // driver: compute expectation (R4, R5, R6), then drive one interval
  task automatic runInterval(input quad_t cyc, input quad_t ins, input quad_t hit,
                             input quad_t miss, input bit edgeEvt);
    expItem_t e;
    longint sum, share[4];
    int tot, left, rank, phase1, phase2, insSum, prevDone;
    sum = 0; tot = 0; phase1 = 0; phase2 = 0; insSum = 0;
    for (int i = 0; i < N; i++) begin
      if (ins[i] == 0) e.cpi[i] = 65535;
      else begin
        e.cpi[i] = (longint'(cyc[i]) * 256) / ins[i];
        if (e.cpi[i] > 65535) e.cpi[i] = 65535;
        if (e.cpi[i] < 1) e.cpi[i] = 1;
      end
      sum += e.cpi[i];
    end
    for (int i = 0; i < N; i++) begin
      share[i] = e.cpi[i] * (WAYS - N) / sum;
      tot += int'(share[i]);
    end
    left = (WAYS - N) - tot;
    for (int i = 0; i < N; i++) begin
      rank = 0;
      for (int j = 0; j < N; j++)
        if (j != i && (e.cpi[j] > e.cpi[i] || (e.cpi[j] == e.cpi[i] && j < i))) rank++;
      e.tgt[i]  = 1 + int'(share[i]) + ((rank < left) ? 1 : 0);
      e.hit[i]  = hit[i] + ((i == 0) ? carryHit0 : 0);
      e.miss[i] = miss[i] + (edgeEvt ? 1 : 0);
      if (cyc[i] > phase1) phase1 = cyc[i];
      if (hit[i] > phase1) phase1 = hit[i];
      if (miss[i] > phase1) phase1 = miss[i];
      if (ins[i] > phase2) phase2 = ins[i];
      insSum += ins[i];
    end
    carryHit0 = edgeEvt ? 1 : 0;
    expQ.push_back(e);
    prevDone = doneCount;
    intervalLen = CW'(insSum);
    // phase 1: cycles, hits, misses
    for (int k = 0; k < phase1; k++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        cycleEvt[i] = (k < cyc[i]);
        hitEvt[i]   = (k < hit[i]);
        missEvt[i]  = (k < miss[i]);
      end
      instrEvt = '0;
    end
    // phase 2: instructions; the last cycle closes the interval (R3)
    for (int k = 0; k < phase2; k++) begin
      @(negedge clk);
      cycleEvt = '0; hitEvt = '0;
      for (int i = 0; i < N; i++) instrEvt[i] = (k < ins[i]);
      missEvt = (edgeEvt && k == phase2 - 1) ? '1 : '0;
    end
    // one cycle after the close: belongs to the next interval (R3)
    @(negedge clk);
    instrEvt = '0; missEvt = '0;
    hitEvt = edgeEvt ? 4'b0001 : 4'b0000;
    @(negedge clk);
    hitEvt = '0;
    wait (doneCount == prevDone + 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < N; i++) begin
      check(wayTarget[i*TW +: TW] == 5'd4, "R1", $sformatf("reset target %0d", i),
            wayTarget[i*TW +: TW], 4);
      check(hitCount[i*CW +: CW] == '0 && missCount[i*CW +: CW] == '0, "R1",
            $sformatf("reset counts %0d", i), hitCount[i*CW +: CW], 0);
    end
    check(updateDone == 1'b0, "R1", "reset done", updateDone, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // equal CPI: even split
    runInterval('{100, 100, 100, 100}, '{50, 50, 50, 50}, '{10, 20, 30, 40}, '{1, 2, 3, 4}, 1'b0);
    // skewed CPI with boundary-cycle and post-boundary events: expect 8,5,2,1
    runInterval('{200, 100, 50, 25}, '{10, 10, 10, 10}, '{5, 0, 7, 0}, '{0, 9, 0, 3}, 1'b1);
    // R4: thread 2 retires nothing -> maximum CPI
    runInterval('{60, 80, 40, 20}, '{20, 40, 0, 5}, '{0, 0, 0, 0}, '{2, 0, 0, 0}, 1'b0);
    // R4 clamp to 1 and R6 tie ranking by index: expect 1,5,5,5
    runInterval('{0, 90, 90, 90}, '{10, 30, 30, 30}, '{1, 1, 1, 1}, '{0, 0, 0, 0}, 1'b0);
    // R4 saturation above 65535
    runInterval('{300, 10, 10, 10}, '{1, 40, 40, 40}, '{3, 0, 0, 0}, '{0, 0, 0, 6}, 1'b1);
    // irregular mix
    runInterval('{33, 47, 51, 29}, '{7, 11, 13, 3}, '{2, 4, 6, 8}, '{8, 6, 4, 2}, 1'b0);

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R8", "all updates seen", expQ.size(), 0);
    finishTest();
  end
endmodule